// File: doc/BRIEF.md
# Saturating Vector Add/Subtract Unit

This unit performs element-wise saturating addition or subtraction on a vector of 128 bits. The element width is 8, 16, 32 or 64 bits, and the elements are read as signed or unsigned. When a true result does not fit the element type, it is clamped to the nearest end of that type's range. The operation covers either the whole vector or only its lower 8 bytes. In the short form, the result bytes above byte 7 are written as zero.

A sticky flag records that saturation happened. Any element inside the operation size that clamps sets the flag to 1. The flag then stays at 1 until a synchronous clear input drops it. Results and flag updates appear on registered outputs one clock after the request strobe. The registered result holds its value between requests.

Elements of 8, 16 and 32 bits are evaluated at one extra bit of precision. Elements of 64 bits decide overflow from comparisons and sign bits, so no wider adder is needed.

Top module: `vsat_unit`

## Requirements
- R1: Signed 8-, 16- and 32-bit elements (`is_signed`=1) give `a+b` (`do_sub`=0) or `a-b` (`do_sub`=1), clamped to [-2^(w-1), 2^(w-1)-1]. The `elem_size` encoding is 0=8, 1=16, 2=32 and 3=64 bits. Element i occupies bits [i*w +: w].
- R2: Unsigned 8-, 16- and 32-bit elements (`is_signed`=0) give the true sum or difference clamped to [0, 2^w-1].
- R3: In a 64-bit unsigned add, a wrapped sum smaller than the first operand marks overflow, and the result is all ones.
- R4: In a 64-bit unsigned subtract, a first operand smaller than the second gives a result of zero.
- R5: In a 64-bit signed add, overflow occurs when both operands have the same sign and the wrapped sum has the other sign. On overflow the result is 0x7FFF_FFFF_FFFF_FFFF if the first operand is non-negative, otherwise 0x8000_0000_0000_0000.
- R6: In a 64-bit signed subtract, overflow occurs when the operand signs differ and the wrapped difference's sign differs from the first operand's sign. The clamp follows the same rule as R5.
- R7: `sat_flag` becomes 1 when any element inside the operation size saturates. An operation in which no element saturates leaves the flag as it was.
- R8: `sat_flag` is sticky. `flag_clr`=1 clears it at the next edge. When a saturating operation arrives in the same cycle as the clear, the flag ends at 1.
- R9: With `full_len`=0, only bytes 0..7 are operated on. Result bits 127:64 become zero, and elements in those bytes cannot set the flag.
- R10: The result of an operation is visible on `res_q` one cycle after `in_valid`. While `in_valid` is low, `res_q` holds its value.
- R11: After reset, `res_q` is zero and `sat_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands and controls are sampled when it is high |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| do_sub | input | 1 | 0 = add, 1 = subtract (opa - opb) |
| is_signed | input | 1 | 1 = signed elements, 0 = unsigned elements |
| elem_size | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| full_len | input | 1 | 1 = operate on 16 bytes, 0 = operate on the low 8 bytes |
| flag_clr | input | 1 | Synchronous clear of the sticky flag |
| res_q | output | 128 | Registered result vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with its default 16-byte vector, so both the full and the short operation sizes can be tested. For 8-bit elements, every operand pair is applied in each of the four sign and operation combinations. Sixteen pairs are packed into each vector, which keeps the complete sweep within a few thousand cycles per mode. The 16-bit and 32-bit widths mix range-edge values with pseudo-random ones. For 64-bit elements, every pair from an eight-value set of corners is applied. Those corners hit each overflow boundary of the sign-bit detection. The expected values come from a wide-precision integer model in the bench.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

    // Width of one 64-bit slice of the vector datapath
    localparam int LANE_BITS = 64;
    // Number of supported element widths (8, 16, 32, 64)
    localparam int NSIZES    = 4;
    // Element slots per slice at the narrowest width
    localparam int MAX_ELEMS = LANE_BITS / 8;

    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_W = 2'd2,
        ESZ_D = 2'd3
    } esz_e;

    typedef struct packed {
        logic sub;
        logic sgn;
        esz_e esz;
    } vsat_op_t;

    function automatic int elem_bits(input int size_code);
        return 8 << size_code;
    endfunction

endpackage

// File: rtl/vsat_elem.sv
module vsat_elem #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic          sub,
    input  logic          sgn,
    output logic [EW-1:0] res,
    output logic          sat
);
    localparam logic [EW-1:0] ONES = '1;
    localparam logic [EW-1:0] SMAX = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] SMIN = {1'b1, {(EW-1){1'b0}}};

    generate
        if (EW < 64) begin : g_ext
            // One guard bit is enough to see the true result for narrow widths
            logic [EW:0] xa, xb, r;
            always_comb begin
                xa = {sgn & a[EW-1], a};
                xb = {sgn & b[EW-1], b};
                r  = sub ? (xa - xb) : (xa + xb);
                if (sgn) begin
                    sat = r[EW] ^ r[EW-1];
                    res = sat ? (r[EW] ? SMIN : SMAX) : r[EW-1:0];
                end else begin
                    // carry out on add, borrow on subtract
                    sat = r[EW];
                    res = sat ? (sub ? '0 : ONES) : r[EW-1:0];
                end
            end
        end else begin : g_signbit
            // Widest elements: no extra adder bit, decide from compares and signs
            logic [EW-1:0] r;
            logic          sa, sb, sr;
            always_comb begin
                r  = sub ? (a - b) : (a + b);
                sa = a[EW-1];
                sb = b[EW-1];
                sr = r[EW-1];
                if (sgn) begin
                    sat = (sub ? (sa != sb) : (sa == sb)) && (sr != sa);
                    res = sat ? (sa ? SMIN : SMAX) : r;
                end else begin
                    sat = sub ? (a < b) : (r < a);
                    res = sat ? (sub ? '0 : ONES) : r;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vsat_chunk.sv
module vsat_chunk
    import vsat_pkg::*;
(
    input  logic [LANE_BITS-1:0] a,
    input  logic [LANE_BITS-1:0] b,
    input  vsat_op_t             op,
    input  logic                 active,
    output logic [LANE_BITS-1:0] res,
    output logic                 sat
);
    logic [NSIZES-1:0][LANE_BITS-1:0] res_by;
    logic [NSIZES-1:0][MAX_ELEMS-1:0] sat_by;

    generate
        for (genvar s = 0; s < NSIZES; s++) begin : g_size
            localparam int EW = elem_bits(s);
            localparam int NE = LANE_BITS / EW;
            for (genvar e = 0; e < NE; e++) begin : g_el
                vsat_elem #(.EW(EW)) u_el (
                    .a   (a[e*EW +: EW]),
                    .b   (b[e*EW +: EW]),
                    .sub (op.sub),
                    .sgn (op.sgn),
                    .res (res_by[s][e*EW +: EW]),
                    .sat (sat_by[s][e])
                );
            end
            if (NE < MAX_ELEMS) begin : g_pad
                assign sat_by[s][MAX_ELEMS-1:NE] = '0;
            end
        end
    endgenerate

    assign res = res_by[op.esz];
    assign sat = active & (|sat_by[op.esz]);

endmodule

// File: rtl/vsat_keep.sv
module vsat_keep #(
    parameter int VEC_BYTES = 16
) (
    input  logic                   full_len,
    output logic [VEC_BYTES*8-1:0] keep
);
    localparam int HALF_BYTES = VEC_BYTES / 2;

    generate
        for (genvar k = 0; k < VEC_BYTES; k++) begin : g_byte
            if (k < HALF_BYTES) begin : g_lo
                assign keep[k*8 +: 8] = 8'hFF;
            end else begin : g_hi
                assign keep[k*8 +: 8] = {8{full_len}};
            end
        end
    endgenerate

endmodule

// File: rtl/vsat_unit.sv
module vsat_unit
    import vsat_pkg::*;
#(
    parameter int VEC_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [VEC_BYTES*8-1:0] opa,
    input  logic [VEC_BYTES*8-1:0] opb,
    input  logic                   do_sub,
    input  logic                   is_signed,
    input  logic [1:0]             elem_size,
    input  logic                   full_len,
    input  logic                   flag_clr,
    output logic [VEC_BYTES*8-1:0] res_q,
    output logic                   sat_flag
);
    localparam int VEC_BITS = VEC_BYTES * 8;
    localparam int NCHUNK   = VEC_BITS / LANE_BITS;
    localparam int HALF_CH  = NCHUNK / 2;

    vsat_op_t            op;
    logic [VEC_BITS-1:0] raw;
    logic [VEC_BITS-1:0] keep;
    logic [NCHUNK-1:0]   chunk_sat;

    assign op.sub = do_sub;
    assign op.sgn = is_signed;
    assign op.esz = esz_e'(elem_size);

    generate
        for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
            logic in_range;
            assign in_range = full_len | (c < HALF_CH);
            vsat_chunk u_chunk (
                .a      (opa[c*LANE_BITS +: LANE_BITS]),
                .b      (opb[c*LANE_BITS +: LANE_BITS]),
                .op     (op),
                .active (in_range),
                .res    (raw[c*LANE_BITS +: LANE_BITS]),
                .sat    (chunk_sat[c])
            );
        end
    endgenerate

    vsat_keep #(.VEC_BYTES(VEC_BYTES)) u_keep (
        .full_len (full_len),
        .keep     (keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q    <= '0;
            sat_flag <= 1'b0;
        end else begin
            if (in_valid) begin
                res_q <= raw & keep;
            end
            sat_flag <= (sat_flag & ~flag_clr) | (in_valid & (|chunk_sat));
        end
    end

endmodule

// File: rtl/vsat_chk.sv
module vsat_chk #(
    parameter int VEC_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [VEC_BYTES*8-1:0] opa,
    input logic                   do_sub,
    input logic                   is_signed,
    input logic [1:0]             elem_size,
    input logic                   full_len,
    input logic                   flag_clr,
    input logic [VEC_BYTES*8-1:0] res_q,
    input logic                   sat_flag
);
    localparam int VEC_BITS = VEC_BYTES * 8;
    localparam int HALF     = VEC_BITS / 2;

    AST_U64_ADD_GE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd3 && !is_signed && !do_sub)
        |=> (res_q[63:0] >= $past(opa[63:0]))); // R3

    AST_U64_SUB_LE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd3 && !is_signed && do_sub)
        |=> (res_q[63:0] <= $past(opa[63:0]))); // R4

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (!sat_flag && !in_valid) |=> !sat_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !flag_clr) |=> sat_flag); // R8

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !in_valid) |=> !sat_flag); // R8

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full_len) |=> (res_q[VEC_BITS-1:HALF] == '0)); // R9

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_q)); // R10

endmodule

bind vsat_unit vsat_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opa       (opa),
    .do_sub    (do_sub),
    .is_signed (is_signed),
    .elem_size (elem_size),
    .full_len  (full_len),
    .flag_clr  (flag_clr),
    .res_q     (res_q),
    .sat_flag  (sat_flag)
);

// File: tb/sim_vsat_unit.sv
module sim_vsat_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] opa, opb;
    logic         do_sub, is_signed, full_len, flag_clr;
    logic [1:0]   elem_size;
    logic [127:0] res_q;
    logic         sat_flag;

    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 1'b0;
    bit           mflag    = 1'b0;
    logic [127:0] mres     = '0;
    logic [31:0]  seed     = 32'h1234_5678;

    always #5 clk = ~clk;

    vsat_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opa       (opa),
        .opb       (opb),
        .do_sub    (do_sub),
        .is_signed (is_signed),
        .elem_size (elem_size),
        .full_len  (full_len),
        .flag_clr  (flag_clr),
        .res_q     (res_q),
        .sat_flag  (sat_flag)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [63:0] wmask(input int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    // Wide-precision reference for one element
    function automatic logic [63:0] ref_sat(input logic [63:0] a, input logic [63:0] b,
                                            input int w, input bit sub, input bit sgn,
                                            output bit sat);
        logic signed [69:0] ea, eb, r, lo, hi;
        logic [63:0] m, xa, xb;
        m = wmask(w);
        if (sgn) begin
            xa = (a & m) | (a[w-1] ? ~m : 64'd0);
            xb = (b & m) | (b[w-1] ? ~m : 64'd0);
            ea = {{6{xa[63]}}, xa};
            eb = {{6{xb[63]}}, xb};
            hi = (70'sd1 <<< (w-1)) - 70'sd1;
            lo = -(70'sd1 <<< (w-1));
        end else begin
            ea = {6'd0, a & m};
            eb = {6'd0, b & m};
            hi = (70'sd1 <<< w) - 70'sd1;
            lo = 70'sd0;
        end
        r   = sub ? (ea - eb) : (ea + eb);
        sat = (r > hi) || (r < lo);
        if (r > hi) r = hi;
        else if (r < lo) r = lo;
        return r[63:0] & m;
    endfunction

    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input bit sub,
                          input bit sgn, input int esz, input bit full, input bit clr,
                          input string tag);
        int           w;
        logic [127:0] exp_v;
        bit           any_sat;
        w       = 8 << esz;
        exp_v   = '0;
        any_sat = 1'b0;
        for (int i = 0; i < 128 / w; i++) begin
            bit          s;
            logic [63:0] r;
            r = ref_sat(64'(a >> (i*w)), 64'(b >> (i*w)), w, sub, sgn, s);
            if ((i*w) < (full ? 128 : 64)) begin
                exp_v   = exp_v | ({64'd0, r} << (i*w));
                any_sat = any_sat | s;
            end
        end
        mflag = (clr ? 1'b0 : mflag) | any_sat;
        mres  = exp_v;
        opa = a; opb = b; do_sub = sub; is_signed = sgn;
        elem_size = 2'(esz); full_len = full; flag_clr = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b0;
        n_checks++;
        if (res_q !== mres || sat_flag !== mflag) begin
            n_fail++;
            $display("FAIL %s: res=%h flag=%b expected res=%h flag=%b",
                     tag, res_q, sat_flag, mres, mflag);
        end
    endtask

    task automatic run_idle(input bit clr, input string tag);
        in_valid = 1'b0;
        flag_clr = clr;
        opa      = ~opa;
        if (clr) mflag = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
        n_checks++;
        if (res_q !== mres || sat_flag !== mflag) begin
            n_fail++;
            $display("FAIL %s: res=%h flag=%b expected res=%h flag=%b",
                     tag, res_q, sat_flag, mres, mflag);
        end
    endtask

    function automatic logic [63:0] corner(input int w, input int k);
        logic [63:0] m;
        m = wmask(w);
        case (k % 6)
            0: return 64'd0;
            1: return 64'd1;
            2: return m;
            3: return m >> 1;
            4: return (m >> 1) + 64'd1;
            default: return m - 64'd1;
        endcase
    endfunction

    function automatic logic [127:0] mixed_vec(input int w);
        logic [127:0] v;
        v = '0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [31:0] pick;
            logic [63:0] e;
            pick = rnd();
            if (pick[1:0] == 2'd0) e = corner(w, int'(pick[7:2]));
            else e = {rnd(), rnd()} & wmask(w);
            v = v | ({64'd0, e} << (i*w));
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] c64 [8];
        rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0; do_sub = 1'b0;
        is_signed = 1'b0; elem_size = 2'd0; full_len = 1'b1; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        n_checks++;
        if (res_q !== '0 || sat_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: res=%h flag=%b expected res=0 flag=0", res_q, sat_flag);
        end

        // R1 R2: exhaustive 8-bit sweep, 16 pairs per vector
        for (int mode = 0; mode < 4; mode++) begin
            for (int base = 0; base < 4096; base++) begin
                logic [127:0] va, vb;
                for (int k = 0; k < 16; k++) begin
                    logic [15:0] p;
                    p = 16'(base * 16 + k);
                    va[k*8 +: 8] = p[15:8];
                    vb[k*8 +: 8] = p[7:0];
                end
                run_op(va, vb, mode[0], mode[1], 0, 1'b1, 1'b1,
                       mode[1] ? "R1 8-bit signed" : "R2 8-bit unsigned");
            end
        end

        // R1 R2: 16- and 32-bit corners mixed with pseudo-random values
        for (int esz = 1; esz < 3; esz++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int n = 0; n < 256; n++) begin
                    run_op(mixed_vec(8 << esz), mixed_vec(8 << esz), mode[0], mode[1], esz,
                           1'b1, 1'b1, mode[1] ? "R1 wide signed" : "R2 wide unsigned");
                end
            end
        end

        // R3 R4 R5 R6: every pair of 64-bit corners
        c64[0] = 64'd0;                 c64[1] = 64'd1;
        c64[2] = 64'h7FFF_FFFF_FFFF_FFFF; c64[3] = 64'h8000_0000_0000_0000;
        c64[4] = 64'hFFFF_FFFF_FFFF_FFFF; c64[5] = 64'hFFFF_FFFF_FFFF_FFFE;
        c64[6] = 64'h4000_0000_0000_0000; c64[7] = 64'hC000_0000_0000_0001;
        for (int mode = 0; mode < 4; mode++) begin
            for (int p = 0; p < 64; p += 2) begin
                string tg;
                case (mode)
                    0: tg = "R3 u64 add";
                    1: tg = "R4 u64 sub";
                    2: tg = "R5 s64 add";
                    default: tg = "R6 s64 sub";
                endcase
                run_op({c64[(p+1)/8], c64[p/8]}, {c64[(p+1)%8], c64[p%8]},
                       mode[0], mode[1], 3, 1'b1, 1'b1, tg);
            end
        end

        // R9: short operation, saturating upper elements must not count
        run_op({64{2'b01}}, {64{2'b01}}, 1'b0, 1'b1, 0, 1'b1, 1'b1, "R9 prefill");
        run_op({64'h7F7F_7F7F_7F7F_7F7F, 64'h0102_0304_0506_0708},
               {64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101},
               1'b0, 1'b1, 0, 1'b0, 1'b1, "R9 short 8-bit");
        run_op({64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd5, 64'd1},
               1'b0, 1'b0, 3, 1'b0, 1'b1, "R9 short 64-bit");
        run_op({64'd3, 64'h0000_0000_7FFF_0010}, {64'd1, 64'h0000_0000_0001_0020},
               1'b0, 1'b1, 1, 1'b0, 1'b1, "R9 short 16-bit saturating");

        // R7 R8 R10: sticky behaviour and hold
        run_op({16{8'h80}}, {16{8'h01}}, 1'b1, 1'b1, 0, 1'b1, 1'b1, "R7 saturating sets flag");
        run_op({16{8'h10}}, {16{8'h01}}, 1'b0, 1'b1, 0, 1'b1, 1'b0, "R8 flag stays set");
        run_idle(1'b0, "R10 result held, flag kept");
        run_idle(1'b0, "R10 result held again");
        run_idle(1'b1, "R8 clear without request");
        run_op({16{8'h10}}, {16{8'h01}}, 1'b0, 1'b0, 0, 1'b1, 1'b0, "R7 no saturation keeps 0");
        run_op({16{8'hF0}}, {16{8'h20}}, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R8 clear with saturation");
        run_op({16{8'h01}}, {16{8'h01}}, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R8 clear with no saturation");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule